// File: doc/BRIEF.md
# Two-Wire Bus State and Start Control Flags

This block holds the bus-state and start-control flags of a two-wire serial bus controller. Two-flop synchronized copies of the clock and data lines are watched for start conditions (data falling while the clock line is high) and stop conditions (data rising while the clock line is high). From these events, and from the controller's operation-enable level, it keeps a bus-busy flag. A start-request-clear flag records when a start attempt failed and the request was dropped.

Two configuration bits sit beside the status flags. The first is a mode bit that lets the controller start right after being enabled without first waiting for a stop. The second turns off the reservation of a start request. Software may change these two bits only while the controller is disabled. All four bits are presented together as one byte, and the busy flag is also brought out on its own pin for the master sequencer.

Top module: `busflag_top`

## Requirements
- R1: After reset the flag byte reads 0x00 and busBusy is 0.
- R2: Bits 5 down to 2 always read 0. Writes to bit 7 (start-request-clear flag) and bit 6 (bus-busy flag) have no effect.
- R3: While opEnable is 0, a write loads wrData bit 1 into the initial-start-enable bit (bit 1) and wrData bit 0 into the reservation-disable bit (bit 0). The new value is visible after the next clock edge.
- R4: While opEnable is 1, writes leave bits 1 and 0 unchanged.
- R5: A start condition on the lines sets bit 6 and busBusy. The change appears on the third clock edge after the data line falls: two edges of synchronizer and one of register.
- R6: When opEnable rises while bit 1 is 0, bit 6 sets on the next edge. When bit 1 is 1, the rise leaves bit 6 at 0.
- R7: Bit 6 clears on a detected stop condition and when opEnable falls from 1 to 0.
- R8: A detected start condition clears bit 1.
- R9: startFail sets bit 7 when bit 0 is 1. When bit 0 is 0, startFail has no effect.
- R10: Bit 7 clears on startReq and when opEnable falls. When a clear and a set reach the same flag in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw clock line level |
| sdaIn | input | 1 | Raw data line level |
| opEnable | input | 1 | Controller operation enable level |
| startReq | input | 1 | Software start request strobe |
| startFail | input | 1 | Start generation failed strobe from the master sequencer |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| flagByte | output | 8 | Flag register read value |
| busBusy | output | 1 | Bus-busy indication |

## Verification
A table of enable, write, request and failure strobes is walked while the lines stay idle. It separates gated from accepted configuration writes. It also separates the two outcomes of enabling, which depend on the mode bit, and tells a failure that is recorded from one that is ignored, including the case where a request and a failure arrive in the same cycle. Directed line sequences then produce a start and a stop condition. They show the exact three-edge latency and separate the start event, which sets busy and clears the mode bit, from the stop event, which only clears busy.

// File: rtl/busflag_pkg.sv
package busflag_pkg;
  localparam int FLAG_W    = 8;
  localparam int BIT_STCLR = 7;
  localparam int BIT_BUSY  = 6;
  localparam int BIT_INIT  = 1;
  localparam int BIT_RSV   = 0;

  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic enRise;
    logic enFall;
    logic cfgWrite;
    logic reqClear;
    logic failSet;
  } flagStrobes_t;
endpackage

// File: rtl/busflag_ctrl.sv
module busflag_ctrl
  import busflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         opEnable,
  input  logic         startReq,
  input  logic         startFail,
  input  logic         wrEn,
  output flagStrobes_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclChain;
  logic [LAST:0] sdaChain;
  logic          sdaPrev;
  logic          sclPrev;
  logic          opPrev;

  generate
    if (SYNC_STAGES > 1) begin : gMulti
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[LAST-1:0], sclIn};
          sdaChain <= {sdaChain[LAST-1:0], sdaIn};
        end
      end
    end else begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaPrev <= 1'b1;
      sclPrev <= 1'b1;
      opPrev  <= 1'b0;
    end else begin
      sdaPrev <= sdaChain[LAST];
      sclPrev <= sclChain[LAST];
      opPrev  <= opEnable;
    end
  end

  logic sclHigh;
  assign sclHigh = sclChain[LAST] & sclPrev;

  always_comb begin
    strb          = '0;
    strb.startDet = sclHigh & sdaPrev & ~sdaChain[LAST];
    strb.stopDet  = sclHigh & ~sdaPrev & sdaChain[LAST];
    strb.enRise   = opEnable & ~opPrev;
    strb.enFall   = ~opEnable & opPrev;
    strb.cfgWrite = wrEn & ~opEnable;
    strb.reqClear = startReq;
    strb.failSet  = startFail;
  end

  assert_no_double_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.enRise |=> !strb.enRise);
  assert_start_after_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.startDet |=> !strb.startDet);
endmodule

// File: rtl/busflag_dp.sv
module busflag_dp
  import busflag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobes_t       strb,
  input  logic [1:0]         cfgData,
  output logic [FLAG_W-1:0]  flagByte,
  output logic               busBusy
);
  logic busyQ;
  logic stClrQ;
  logic initQ;
  logic rsvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      stClrQ <= 1'b0;
      initQ  <= 1'b0;
      rsvQ   <= 1'b0;
    end else begin
      if (strb.stopDet || strb.enFall)
        busyQ <= 1'b0;
      else if (strb.startDet || (strb.enRise && !initQ))
        busyQ <= 1'b1;

      if (strb.reqClear || strb.enFall)
        stClrQ <= 1'b0;
      else if (strb.failSet && rsvQ)
        stClrQ <= 1'b1;

      if (strb.startDet)
        initQ <= 1'b0;
      else if (strb.cfgWrite)
        initQ <= cfgData[1];

      if (strb.cfgWrite)
        rsvQ <= cfgData[0];
    end
  end

  always_comb begin
    flagByte            = '0;
    flagByte[BIT_STCLR] = stClrQ;
    flagByte[BIT_BUSY]  = busyQ;
    flagByte[BIT_INIT]  = initQ;
    flagByte[BIT_RSV]   = rsvQ;
  end
  assign busBusy = busyQ;

  assert_busy_clear_on_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopDet || strb.enFall) |=> !busyQ);
  assert_busy_set_on_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startDet && !strb.enFall) |=> busyQ);
  assert_init_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.startDet |=> !initQ);
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reqClear || strb.enFall) |=> !stClrQ);
  assert_fail_needs_rsv_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stClrQ && !rsvQ) |=> !stClrQ);
endmodule

// File: rtl/busflag_top.sv
module busflag_top
  import busflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        opEnable,
  input  logic        startReq,
  input  logic        startFail,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  flagByte,
  output logic        busBusy
);
  flagStrobes_t strb;
  logic         unusedWrBits;

  assign unusedWrBits = ^wrData[7:2];

  busflag_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .opEnable(opEnable), .startReq(startReq), .startFail(startFail),
    .wrEn(wrEn), .strb(strb)
  );

  busflag_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgData({wrData[BIT_INIT], wrData[BIT_RSV]}),
    .flagByte(flagByte), .busBusy(busBusy)
  );

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    opEnable |=> $stable(flagByte[BIT_RSV]));
  assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    flagByte[5:2] == 4'b0000);
  assert_busy_pin_R5: assert property (@(posedge clk) disable iff (!rstN)
    busBusy == flagByte[BIT_BUSY]);
endmodule

// File: tb/busflag_top_tb_top.sv
module busflag_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic opEnable = 1'b0, startReq = 1'b0, startFail = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] flagByte;
  logic busBusy;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  busflag_top dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .opEnable(opEnable), .startReq(startReq), .startFail(startFail),
    .wrEn(wrEn), .wrData(wrData), .flagByte(flagByte), .busBusy(busBusy)
  );

  // Entry: [23:20] requirement, [19] opEnable, [18] wrEn, [17:10] wrData,
  //        [9] startReq, [8] startFail, [7:0] expected flag byte
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3,  1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h03}, // R2 R3 upper bits ignored
    {4'd3,  1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00}, // R3 clear both
    {4'd3,  1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h01}, // R3 reservation-disable
    {4'd6,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h41}, // R6 enable sets busy
    {4'd4,  1'b1, 1'b1, 8'h02, 1'b0, 1'b0, 8'h41}, // R4 write ignored
    {4'd9,  1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC1}, // R9 failure recorded
    {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h41}, // R10 request clears
    {4'd10, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h41}, // R10 clear wins
    {4'd9,  1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC1}, // R9 again
    {4'd7,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01}, // R7 R10 enable fall
    {4'd3,  1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 8'h02}, // R3 initial-start mode
    {4'd6,  1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02}, // R6 busy stays low
    {4'd9,  1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h02}, // R9 ignored without bit 0
    {4'd7,  1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h02}  // R7 disable again
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", flagByte, 8'h00);
    check("R1", {7'd0, busBusy}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      opEnable  = VEC[i][19];
      wrEn      = VEC[i][18];
      wrData    = VEC[i][17:10];
      startReq  = VEC[i][9];
      startFail = VEC[i][8];
      @(negedge clk);
      check($sformatf("R%0d", VEC[i][23:20]), flagByte, VEC[i][7:0]);
    end
    wrEn = 1'b0; startReq = 1'b0; startFail = 1'b0;

    // R5 R8: start condition with initial-start mode set (flag 0x02)
    sdaIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R5", flagByte, 8'h02);
    @(negedge clk);
    check("R5", flagByte, 8'h40);
    check("R8", {7'd0, busBusy}, 8'h01);

    // R7: stop condition clears busy
    sdaIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", flagByte, 8'h00);

    // R2: writes to status bits have no effect
    wrEn = 1'b1; wrData = 8'hC0;
    @(negedge clk);
    wrEn = 1'b0;
    check("R2", flagByte, 8'h00);

    // R5: data toggling while clock line is low is not a start
    sclIn = 1'b0;
    @(negedge clk);
    sdaIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R5", flagByte, 8'h00);
    sdaIn = 1'b1;
    repeat (2) @(negedge clk);
    sclIn = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset mid-operation returns to zero
    wrEn = 1'b1; wrData = 8'h03;
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", flagByte, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule